// File: doc/BRIEF.md
# Motor Bridge Enable and Fault Supervisor

This block decides from moment to moment whether the two power bridges of a stepper-motor driver may conduct and whether the step indexer may accept step pulses. It combines three active-low control inputs (reset, enable, sleep) with three protection events that the analog sense circuits deliver as synchronous digital signals: overcurrent on any power switch, over-temperature, and supply undervoltage. It drives a bridge enable, an indexer home/reset request, a step-accept qualifier, a run enable for the internal clocks, charge pump and regulator, and an active-low fault flag. The fault flag is meant to go to an open-drain pad: 0 pulls the pad low and 1 releases it.

An overcurrent event must stay present for a qualification window before it counts. After that window it shuts the bridges down and the shutdown stays latched until reset, or until the supply drops and recovers. Over-temperature shuts the bridges down only while it is present. Undervoltage stops everything and resets the logic. Sleep stops the clocks and the bridges and masks every other control input. After sleep is released, step pulses stay blocked until a wake-up settle time has passed.

Top module: `drv_supervisor`

## Requirements
- R1: While `rst_req_n` is 0 and the block is awake (`sleep_n` = 1, `uvlo_evt` = 0), `bridge_en` and `step_ok` are 0 and `idx_rst` is 1 in the same cycle.
- R2: While awake and out of reset with no fault, `en_n` = 1 forces `bridge_en` and `step_ok` to 0, and `en_n` = 0 sets `bridge_en` to 1 in the same cycle.
- R3: While `sleep_n` is 0, `bridge_en`, `clk_run`, `step_ok` and `idx_rst` are 0, and `rst_req_n` has no effect: a latched overcurrent shutdown is still present on `fault_n` after wake-up.
- R4: From the cycle in which `sleep_n` returns to 1, `step_ok` stays 0 for WAKE_CYC clock edges. It becomes 1 after the WAKE_CYC-th edge if the bridge is enabled.
- R5: Any set bit of `ocp_evt` counts as an overcurrent event. If the event lasts fewer than OCP_QUAL consecutive sampled cycles, nothing latches. The qualification count restarts from zero whenever the event drops for a cycle.
- R6: An overcurrent event present for OCP_QUAL consecutive sampled cycles latches a shutdown after the OCP_QUAL-th edge: `fault_n` = 0 and `bridge_en` = 0. The latch survives removal of the event and changes of `en_n`. It is cleared by an awake reset or by undervoltage.
- R7: While `otemp_evt` is 1 and the block is awake, `fault_n` and `bridge_en` are 0. Both recover in the cycle the event clears, without any reset.
- R8: While `uvlo_evt` is 1, `bridge_en`, `clk_run` and `step_ok` are 0 and `idx_rst` is 1. After the next clock edge any latched overcurrent is cleared.
- R9: `fault_n` is 1 whenever no overcurrent is latched and no awake over-temperature is present. This includes the state after power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| por_n | input | 1 | Asynchronous power-on reset, active low (supply applied) |
| rst_req_n | input | 1 | Logic reset request, active low |
| en_n | input | 1 | Bridge/indexer enable, active low |
| sleep_n | input | 1 | Sleep request, active low |
| ocp_evt | input | NSW | Per-switch overcurrent events, active high |
| otemp_evt | input | 1 | Over-temperature event, active high |
| uvlo_evt | input | 1 | Supply undervoltage event, active high |
| bridge_en | output | 1 | Bridges may conduct |
| idx_rst | output | 1 | Send indexer to home state |
| step_ok | output | 1 | Step edges may be accepted |
| clk_run | output | 1 | Internal clocks, charge pump and regulator run |
| fault_n | output | 1 | Fault flag for an open-drain pad; 0 pulls low |

## Verification
The hardest state to reach is a latched overcurrent that meets a reset request while the block is asleep, because sleep must mask the reset. The bench first latches the fault with a sustained event, then enters sleep, pulses reset, wakes up and checks that the flag is still low. A second difficult point is the edge of the qualification window. The bench drives bursts one cycle short of OCP_QUAL, separated by a single quiet cycle, to show that the count restarts. It also drives one burst of exactly OCP_QUAL cycles to find the edge where the latch sets.

// File: rtl/drv_sup_pkg.sv
package drv_sup_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,  // supply low: everything stopped, logic held reset
    ST_SLEEP = 3'd1,  // sleeping: clocks stopped, inputs masked
    ST_HOLD  = 3'd2,  // reset request: indexer home, bridges off
    ST_IDLE  = 3'd3,  // disabled or faulted: bridges off
    ST_RUN   = 3'd4   // bridges on
  } sup_state_e;

  // Priority order of the supervisor: supply, sleep, reset, fault/enable.
  function automatic sup_state_e pick_state(input logic uvlo, input logic sleep_n,
                                            input logic rst_n, input logic fault,
                                            input logic en_n);
    if (uvlo)              return ST_OFF;
    else if (!sleep_n)     return ST_SLEEP;
    else if (!rst_n)       return ST_HOLD;
    else if (fault || en_n) return ST_IDLE;
    else                   return ST_RUN;
  endfunction

  // Saturating down-count used by the wake timer.
  function automatic logic [31:0] sat_dec(input logic [31:0] v);
    return (v == 32'd0) ? 32'd0 : v - 32'd1;
  endfunction

endpackage

// File: rtl/drv_ocp_qual.sv
module drv_ocp_qual #(
  parameter int NSW      = 4,
  parameter int OCP_QUAL = 16
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           awake,
  input  logic           clr,
  input  logic [NSW-1:0] evt,
  output logic           latched
);
  localparam int CW = $clog2(OCP_QUAL + 1);
  localparam logic [CW-1:0] LAST = CW'(OCP_QUAL - 1);

  logic          evt_any;
  logic [CW-1:0] cnt;

  assign evt_any = |evt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt     <= '0;
      latched <= 1'b0;
    end else if (clr) begin
      cnt     <= '0;
      latched <= 1'b0;
    end else if (!awake || !evt_any || latched) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt     <= '0;
      latched <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: a latched shutdown stays until a clear arrives
  p_latch_holds_r6: assert property (@(posedge clk) disable iff (!por_n)
    latched && !clr |=> latched);

  // R5: the latch only sets at the end of a full qualification run
  p_no_early_latch_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(latched) |-> $past(evt_any) && $past(cnt) == LAST);

  // R8: a clear request empties the latch on the next edge
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!por_n)
    clr |=> !latched);

endmodule

// File: rtl/drv_wake_timer.sv
module drv_wake_timer #(
  parameter int WAKE_CYC = 1000
) (
  input  logic clk,
  input  logic por_n,
  input  logic sleeping,
  output logic done
);
  import drv_sup_pkg::*;

  localparam int TW = $clog2(WAKE_CYC + 1);
  localparam logic [TW-1:0] LOAD = TW'(WAKE_CYC);

  logic [TW-1:0] remain;
  logic [31:0]   remain_next;

  assign remain_next = sat_dec(32'(remain));
  assign done = (remain == '0) && !sleeping;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        remain <= '0;
    else if (sleeping) remain <= LOAD;
    else               remain <= remain_next[TW-1:0];
  end

  // R4: no completion in the cycle that follows a sleep cycle
  p_not_done_after_sleep_r4: assert property (@(posedge clk) disable iff (!por_n)
    sleeping |=> !done);

endmodule

// File: rtl/drv_supervisor.sv
module drv_supervisor #(
  parameter int NSW      = 4,
  parameter int OCP_QUAL = 16,
  parameter int WAKE_CYC = 1000
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           rst_req_n,
  input  logic           en_n,
  input  logic           sleep_n,
  input  logic [NSW-1:0] ocp_evt,
  input  logic           otemp_evt,
  input  logic           uvlo_evt,
  output logic           bridge_en,
  output logic           idx_rst,
  output logic           step_ok,
  output logic           clk_run,
  output logic           fault_n
);
  import drv_sup_pkg::*;

  // named internal events
  logic       logic_clr;
  logic       ocp_latched;
  logic       otemp_live;
  logic       fault_any;
  logic       wake_done;
  sup_state_e state;

  assign logic_clr  = uvlo_evt || (sleep_n && !rst_req_n);
  assign otemp_live = otemp_evt && sleep_n;
  assign fault_any  = ocp_latched || otemp_live;

  drv_ocp_qual #(.NSW(NSW), .OCP_QUAL(OCP_QUAL)) ocp_i (
    .clk(clk), .por_n(por_n), .awake(sleep_n && !uvlo_evt),
    .clr(logic_clr), .evt(ocp_evt), .latched(ocp_latched)
  );

  drv_wake_timer #(.WAKE_CYC(WAKE_CYC)) wake_i (
    .clk(clk), .por_n(por_n), .sleeping(!sleep_n), .done(wake_done)
  );

  assign state     = pick_state(uvlo_evt, sleep_n, rst_req_n, fault_any, en_n);
  assign bridge_en = (state == ST_RUN);
  assign step_ok   = (state == ST_RUN) && wake_done;
  assign idx_rst   = (state == ST_OFF) || (state == ST_HOLD);
  assign clk_run   = (state != ST_OFF) && (state != ST_SLEEP);
  assign fault_n   = !fault_any;

  // R1: reset request keeps the bridges off and the indexer at home
  p_reset_holds_r1: assert property (@(posedge clk) disable iff (!por_n)
    !rst_req_n && sleep_n && !uvlo_evt |-> !bridge_en && !step_ok && idx_rst);

  // R3: sleeping stops clocks and bridges
  p_sleep_quiet_r3: assert property (@(posedge clk) disable iff (!por_n)
    !sleep_n |-> !clk_run && !bridge_en && !step_ok);

  // R4: steps are refused in the first cycle after wake-up
  p_wake_blocks_r4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sleep_n) |-> !step_ok);

  // R7: an awake over-temperature shows on the fault pin
  p_otemp_flag_r7: assert property (@(posedge clk) disable iff (!por_n)
    otemp_evt && sleep_n |-> !fault_n && !bridge_en);

  // R8: undervoltage stops everything
  p_uvlo_stop_r8: assert property (@(posedge clk) disable iff (!por_n)
    uvlo_evt |-> !clk_run && !bridge_en && idx_rst);

  // R2/R6: bridge may only run when enabled and free of faults
  p_run_needs_clean_r2: assert property (@(posedge clk) disable iff (!por_n)
    bridge_en |-> !en_n && fault_n);

endmodule

// File: tb/drv_supervisor_tb.sv
module drv_supervisor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSW  = 4;
  localparam int QUAL = 6;
  localparam int WAKE = 20;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_req_n = 1'b1, en_n = 1'b1, sleep_n = 1'b1;
  logic [NSW-1:0] ocp_evt = '0;
  logic otemp_evt = 1'b0, uvlo_evt = 1'b0;
  logic bridge_en, idx_rst, step_ok, clk_run, fault_n;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drv_supervisor #(.NSW(NSW), .OCP_QUAL(QUAL), .WAKE_CYC(WAKE)) dut_i (
    .clk(clk), .por_n(por_n), .rst_req_n(rst_req_n), .en_n(en_n), .sleep_n(sleep_n),
    .ocp_evt(ocp_evt), .otemp_evt(otemp_evt), .uvlo_evt(uvlo_evt),
    .bridge_en(bridge_en), .idx_rst(idx_rst), .step_ok(step_ok),
    .clk_run(clk_run), .fault_n(fault_n)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // n rising edges, then land at the following falling edge
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle(); #1; endtask

  task automatic t_reset_state();
    settle();
    chk("R9", "fault_n after power-on", fault_n, 1'b1);
    chk("R2", "bridge_en disabled", bridge_en, 1'b0);
    rst_req_n = 1'b0; en_n = 1'b0; settle();
    chk("R1", "bridge_en in reset", bridge_en, 1'b0);
    chk("R1", "idx_rst in reset", idx_rst, 1'b1);
    chk("R1", "step_ok in reset", step_ok, 1'b0);
    tick(1);
    rst_req_n = 1'b1; settle();
    chk("R1", "idx_rst released", idx_rst, 1'b0);
  endtask

  task automatic t_enable();
    en_n = 1'b0; settle();
    chk("R2", "bridge_en enabled", bridge_en, 1'b1);
    chk("R2", "step_ok enabled", step_ok, 1'b1);
    chk("R2", "clk_run awake", clk_run, 1'b1);
    tick(1);
    en_n = 1'b1; settle();
    chk("R2", "bridge_en off", bridge_en, 1'b0);
    chk("R2", "step_ok off", step_ok, 1'b0);
    tick(1);
    en_n = 1'b0; settle();
  endtask

  task automatic t_ocp_short();
    ocp_evt = 4'b0100; tick(QUAL - 1);
    chk("R5", "no latch before window", fault_n, 1'b1);
    ocp_evt = 4'b0000; tick(1);
    ocp_evt = 4'b0001; tick(QUAL - 1);
    chk("R5", "count restarted", fault_n, 1'b1);
    chk("R5", "bridge still on", bridge_en, 1'b1);
    ocp_evt = 4'b0000; tick(2);
    chk("R5", "no late latch", fault_n, 1'b1);
  endtask

  task automatic t_ocp_latch();
    ocp_evt = 4'b1000; tick(QUAL - 1);
    chk("R6", "one edge before latch", fault_n, 1'b1);
    tick(1);
    chk("R6", "fault_n latched", fault_n, 1'b0);
    chk("R6", "bridge_en off", bridge_en, 1'b0);
    ocp_evt = '0; en_n = 1'b1; tick(3); en_n = 1'b0; settle();
    chk("R6", "latch survives", fault_n, 1'b0);
    chk("R6", "bridge stays off", bridge_en, 1'b0);
  endtask

  task automatic t_sleep_masks_reset();
    sleep_n = 1'b0; settle();
    chk("R3", "clk_run asleep", clk_run, 1'b0);
    chk("R3", "bridge_en asleep", bridge_en, 1'b0);
    chk("R3", "idx_rst asleep", idx_rst, 1'b0);
    rst_req_n = 1'b0; settle();
    chk("R3", "idx_rst ignores reset", idx_rst, 1'b0);
    tick(2); rst_req_n = 1'b1; tick(1);
    sleep_n = 1'b1; settle();
    chk("R3", "latch kept over sleep reset", fault_n, 1'b0);
    rst_req_n = 1'b0; tick(1); rst_req_n = 1'b1; settle();
    chk("R6", "awake reset clears latch", fault_n, 1'b1);
    chk("R9", "flag released", fault_n, 1'b1);
  endtask

  task automatic t_wake_delay();
    sleep_n = 1'b0; tick(2);
    chk("R3", "step_ok asleep", step_ok, 1'b0);
    sleep_n = 1'b1; settle();
    chk("R4", "bridge on at wake", bridge_en, 1'b1);
    chk("R4", "step blocked at wake", step_ok, 1'b0);
    tick(WAKE - 1);
    chk("R4", "step blocked last cycle", step_ok, 1'b0);
    tick(1);
    chk("R4", "step accepted", step_ok, 1'b1);
  endtask

  task automatic t_otemp();
    otemp_evt = 1'b1; settle();
    chk("R7", "fault_n in otemp", fault_n, 1'b0);
    chk("R7", "bridge_en in otemp", bridge_en, 1'b0);
    tick(4);
    otemp_evt = 1'b0; settle();
    chk("R7", "fault_n recovered", fault_n, 1'b1);
    chk("R7", "bridge_en recovered", bridge_en, 1'b1);
  endtask

  task automatic t_uvlo();
    ocp_evt = 4'b0010; tick(QUAL); ocp_evt = '0;
    chk("R6", "latched before uvlo", fault_n, 1'b0);
    uvlo_evt = 1'b1; settle();
    chk("R8", "clk_run in uvlo", clk_run, 1'b0);
    chk("R8", "idx_rst in uvlo", idx_rst, 1'b1);
    chk("R8", "step_ok in uvlo", step_ok, 1'b0);
    tick(1);
    chk("R8", "latch cleared", fault_n, 1'b1);
    uvlo_evt = 1'b0; settle();
    chk("R8", "bridge back after uvlo", bridge_en, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    por_n = 1'b1;
    tick(1);
    t_reset_state();
    t_enable();
    t_ocp_short();
    t_ocp_latch();
    t_sleep_masks_reset();
    t_wake_delay();
    t_otemp();
    t_uvlo();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule